// File: doc/BRIEF.md
# Accumulator Shift and Field Extract Unit

This block turns a 64-bit signed accumulator into a 32-bit result in one of two styles. In shift style it applies an arithmetic right shift by a 5-bit amount. Rounding is optional, and so is clamping to the signed 32-bit range. Any overflow is recorded in a sticky bit of a 32-bit control word. In field style it cuts a bit field out of the accumulator. The field ends at a position pointer held in the control word, and its width comes from the amount operand. The unit reports whether the extract fitted, and it can optionally move the pointer down past the field it consumed.

The caller presents an accumulator, an amount, mode and option bits, and the current control word, together with a valid strobe. One cycle later the unit returns the result and the updated control word. Storage of the accumulator and of the control word stays with the caller.

Top module: `afx_unit`

## Requirements
- R1: Only the low 5 bits of `in_amt` are used as the shift amount; an amount of zero yields the low 32 bits of the accumulator.
- R2: In shift style without rounding, the result is the low 32 bits of the accumulator arithmetically shifted right by the amount.
- R3: With rounding and a nonzero amount, 2^(amount-1) is added to the accumulator before the shift; with an amount of zero rounding has no effect.
- R4: Overflow is raised when the unshifted accumulator lies outside [-2^31, 2^31-1]; a value exactly at either limit raises none. Overflow sets control bit 23, and the unit never clears that bit.
- R5: On overflow with saturation on, the shifted value is clamped to 0x7FFFFFFF or 0x80000000 when it does not fit in 32 bits. With saturation off, the low 32 bits are returned.
- R6: If rounding turns a positive accumulator negative, overflow is raised; with saturation on, the rounded value is replaced by the 64-bit signed maximum before the shift.
- R7: In field style the pointer is control bits 5:0 and the size is the low 5 bits of `in_amt`. When pointer >= size, the result is accumulator bits [pointer : pointer-size], zero-extended, and control bit 14 is cleared.
- R8: When pointer < size, the result is 0, control bit 14 is set, and the pointer is left unchanged.
- R9: With decrement on and a valid extract, control bits 5:0 become pointer-size-1, or 63 when pointer equals size; otherwise the pointer is unchanged.
- R10: Shift style changes only control bit 23; field style changes only control bits 14 and 5:0. All other control bits pass through.
- R11: Results are registered. `out_valid` is `in_valid` delayed by one cycle, and the result and control outputs hold while `in_valid` is low. Synchronous reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 1 | 0 = shift style, 1 = field style |
| in_round | input | 1 | Round before shifting (shift style) |
| in_sat | input | 1 | Clamp on overflow (shift style) |
| in_dec | input | 1 | Move pointer after a valid extract (field style) |
| in_acc | input | 64 | Accumulator value |
| in_amt | input | 8 | Shift amount or field size (low 5 bits used) |
| in_ctl | input | 32 | Current control word |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 32 | Result value |
| out_ctl | output | 32 | Updated control word |

## Verification
A wrong internal decision shows at the ports on the cycle after the request and nowhere later, because the unit holds no state between operations. A bad overflow detector shows as a bit 23 that is wrong or lost in `out_ctl`, or as an unclamped result. A mistaken pointer comparison shows as a zero result paired with a wrong bit 14, or as a pointer in bits 5:0 that wraps wrongly. The vectors sit at the edges where these faults would first appear: values exactly at the limits, pointer equal to size, rounding carry out of the top bit, and a full 32-bit field.

// File: rtl/afx_pkg.sv
package afx_pkg;
  localparam logic MODE_SHIFT = 1'b0;
  localparam logic MODE_FIELD = 1'b1;
endpackage

// File: rtl/afx_shift_path.sv
module afx_shift_path #(
  parameter int ACC_W = 64,
  parameter int RES_W = 32,
  parameter int SH_W  = 5
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [SH_W-1:0]  sh,
  input  logic             rnd,
  input  logic             sat,
  output logic [RES_W-1:0] res,
  output logic             ovf
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [RES_W-1:0] RES_MAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] RES_MIN = {1'b1, {(RES_W-1){1'b0}}};

  logic                    do_rnd, acc_pos, carry_ovf, range_ovf, fits;
  logic [ACC_W-1:0]        half, sum;
  logic signed [ACC_W-1:0] pre, shifted;

  always_comb begin
    do_rnd    = rnd && (sh != '0);
    half      = ACC_W'(1) << (sh - SH_W'(1));
    sum       = acc + half;
    acc_pos   = !acc[ACC_W-1] && (acc != '0);
    carry_ovf = do_rnd && acc_pos && sum[ACC_W-1];
    if (do_rnd) pre = (carry_ovf && sat) ? ACC_MAX : sum;
    else        pre = acc;
    shifted   = pre >>> sh;
    range_ovf = !((&acc[ACC_W-1:RES_W-1]) || !(|acc[ACC_W-1:RES_W-1]));
    ovf       = carry_ovf || range_ovf;
    fits      = (&shifted[ACC_W-1:RES_W-1]) || !(|shifted[ACC_W-1:RES_W-1]);
    if (ovf && sat && !fits) res = shifted[ACC_W-1] ? RES_MIN : RES_MAX;
    else                     res = shifted[RES_W-1:0];
  end
endmodule

// File: rtl/afx_field_path.sv
module afx_field_path #(
  parameter int ACC_W = 64,
  parameter int RES_W = 32,
  parameter int POS_W = 6,
  parameter int SZ_W  = 5
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [POS_W-1:0] pos,
  input  logic [SZ_W-1:0]  size,
  input  logic             dec,
  output logic [RES_W-1:0] res,
  output logic             fail,
  output logic [POS_W-1:0] pos_next
);
  logic [POS_W-1:0] size_w, lo;
  logic [SZ_W:0]    cnt;
  logic [RES_W:0]   mask;
  logic [ACC_W-1:0] win;
  logic             ok;

  always_comb begin
    size_w = POS_W'(size);
    ok     = pos >= size_w;
    lo     = pos - size_w;
    win    = acc >> lo;
    cnt    = {1'b0, size} + (SZ_W+1)'(1);
    mask   = ((RES_W+1)'(1) << cnt) - (RES_W+1)'(1);
    res    = ok ? (win[RES_W-1:0] & mask[RES_W-1:0]) : '0;
    fail   = !ok;
    if (ok && dec) pos_next = (pos == size_w) ? '1 : (pos - size_w - POS_W'(1));
    else           pos_next = pos;
  end

  always_comb begin
    if (ok) assert (pos_next <= pos || pos == size_w) else $error("pointer grew R9");
  end
endmodule

// File: rtl/afx_unit.sv
module afx_unit #(
  parameter int ACC_W    = 64,
  parameter int RES_W    = 32,
  parameter int CTL_W    = 32,
  parameter int AMT_IN_W = 8,
  parameter int SH_W     = 5,
  parameter int POS_W    = 6,
  parameter int OVF_BIT  = 23,
  parameter int FAIL_BIT = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_mode,
  input  logic                in_round,
  input  logic                in_sat,
  input  logic                in_dec,
  input  logic [ACC_W-1:0]    in_acc,
  input  logic [AMT_IN_W-1:0] in_amt,
  input  logic [CTL_W-1:0]    in_ctl,
  output logic                out_valid,
  output logic [RES_W-1:0]    out_result,
  output logic [CTL_W-1:0]    out_ctl
);
  import afx_pkg::*;

  logic [SH_W-1:0]  amt5;
  logic [RES_W-1:0] sh_res, fd_res, res_d;
  logic             sh_ovf, fd_fail;
  logic [POS_W-1:0] fd_pos;
  logic [CTL_W-1:0] ctl_d;

  assign amt5 = in_amt[SH_W-1:0];

  afx_shift_path #(.ACC_W(ACC_W), .RES_W(RES_W), .SH_W(SH_W)) u_shift (
    .acc(in_acc), .sh(amt5), .rnd(in_round), .sat(in_sat),
    .res(sh_res), .ovf(sh_ovf)
  );

  afx_field_path #(.ACC_W(ACC_W), .RES_W(RES_W), .POS_W(POS_W), .SZ_W(SH_W)) u_field (
    .acc(in_acc), .pos(in_ctl[POS_W-1:0]), .size(amt5), .dec(in_dec),
    .res(fd_res), .fail(fd_fail), .pos_next(fd_pos)
  );

  always_comb begin
    ctl_d = in_ctl;
    if (in_mode == MODE_FIELD) begin
      res_d               = fd_res;
      ctl_d[FAIL_BIT]     = fd_fail;
      ctl_d[POS_W-1:0]    = fd_pos;
    end else begin
      res_d               = sh_res;
      if (sh_ovf) ctl_d[OVF_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ctl    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= res_d;
        out_ctl    <= ctl_d;
      end
    end
  end

  assert_valid_follow_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drop_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_shift_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_mode) == MODE_SHIFT) |->
      (out_ctl[FAIL_BIT] == $past(in_ctl[FAIL_BIT]) &&
       out_ctl[POS_W-1:0] == $past(in_ctl[POS_W-1:0])));
  assert_field_keeps_ovf_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_mode) == MODE_FIELD) |-> out_ctl[OVF_BIT] == $past(in_ctl[OVF_BIT]));
  assert_fail_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_mode) == MODE_FIELD && out_ctl[FAIL_BIT]) |-> out_result == '0);
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_mode) == MODE_SHIFT && $past(in_ctl[OVF_BIT])) |-> out_ctl[OVF_BIT]);
endmodule

// File: tb/tb_afx_unit.sv
module tb_afx_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  typedef struct packed {
    logic        mode;
    logic        rnd;
    logic        sat;
    logic        dec;
    logic [63:0] acc;
    logic [7:0]  amt;
    logic [31:0] ctl;
    logic [31:0] er;
    logic [31:0] ec;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,64'h0000_0000_1234_5678,8'h00,32'h0,32'h1234_5678,32'h0,8'd1},        // R1 zero shift
    '{1'b0,1'b0,1'b0,1'b0,64'h0000_0000_0000_0100,8'h24,32'h0,32'h0000_0010,32'h0,8'd1},        // R1 upper amt bits ignored
    '{1'b0,1'b0,1'b0,1'b0,64'hFFFF_FFFF_FFFF_FF00,8'h04,32'h0,32'hFFFF_FFF0,32'h0,8'd2},        // R2 negative shift
    '{1'b0,1'b1,1'b0,1'b0,64'h0000_0000_0000_0018,8'h04,32'h0,32'h0000_0002,32'h0,8'd3},        // R3 round up
    '{1'b0,1'b1,1'b0,1'b0,64'hFFFF_FFFF_FFFF_FFE8,8'h04,32'h0,32'hFFFF_FFFF,32'h0,8'd3},        // R3 round negative
    '{1'b0,1'b1,1'b1,1'b0,64'h0000_0000_7FFF_FFFF,8'h00,32'h0,32'h7FFF_FFFF,32'h0,8'd4},        // R4 at max, no ovf
    '{1'b0,1'b0,1'b0,1'b0,64'hFFFF_FFFF_8000_0000,8'h00,32'h0,32'h8000_0000,32'h0,8'd4},        // R4 at min, no ovf
    '{1'b0,1'b0,1'b0,1'b0,64'h0000_0001_0000_0005,8'h00,32'h0,32'h0000_0005,32'h0080_0000,8'd5},// R5 wrap
    '{1'b0,1'b0,1'b1,1'b0,64'h0000_0001_0000_0005,8'h00,32'h0,32'h7FFF_FFFF,32'h0080_0000,8'd5},// R5 clamp high
    '{1'b0,1'b0,1'b1,1'b0,64'h0000_0001_0000_0000,8'h08,32'h0,32'h0100_0000,32'h0080_0000,8'd4},// R4 flag on unshifted value
    '{1'b0,1'b0,1'b1,1'b0,64'hFFFF_FFF0_0000_0000,8'h04,32'h0,32'h8000_0000,32'h0080_0000,8'd5},// R5 clamp low
    '{1'b0,1'b1,1'b1,1'b0,64'h7FFF_FFFF_FFFF_FFFF,8'h01,32'h0,32'h7FFF_FFFF,32'h0080_0000,8'd6},// R6 carry, sat
    '{1'b0,1'b1,1'b0,1'b0,64'h7FFF_FFFF_FFFF_FFFF,8'h01,32'h0080_0000,32'h0,32'h0080_0000,8'd6},// R6 carry, wrap
    '{1'b0,1'b0,1'b0,1'b0,64'h1,8'h00,32'hFF7F_FFFF,32'h1,32'hFF7F_FFFF,8'd10},                 // R10 shift passthrough
    '{1'b1,1'b0,1'b0,1'b0,64'h0000_0000_0000_AB00,8'hE7,32'h0000_000F,32'hAB,32'h0000_000F,8'd7},// R7 extract
    '{1'b1,1'b0,1'b0,1'b0,64'h0000_0000_0000_AB00,8'h07,32'h0000_400F,32'hAB,32'h0000_000F,8'd7},// R7 clears bit 14
    '{1'b1,1'b0,1'b0,1'b0,64'h0000_0000_0000_AB00,8'h07,32'h0000_0003,32'h0,32'h0000_4003,8'd8}, // R8 fail
    '{1'b1,1'b0,1'b0,1'b1,64'h0000_0000_0000_AB00,8'h07,32'h0000_000F,32'hAB,32'h0000_0007,8'd9},// R9 decrement
    '{1'b1,1'b0,1'b0,1'b1,64'h0000_0000_0000_00AB,8'h07,32'h0000_0007,32'hAB,32'h0000_003F,8'd9},// R9 wrap to 63
    '{1'b1,1'b0,1'b0,1'b1,64'h0000_0000_0000_AB00,8'h07,32'h0000_0003,32'h0,32'h0000_4003,8'd9}, // R9 fail keeps pointer
    '{1'b1,1'b0,1'b0,1'b1,64'hDEAD_BEEF_0000_0000,8'h1F,32'hFF80_003F,32'hDEAD_BEEF,32'hFF80_001F,8'd10},// R10 full width
    '{1'b1,1'b0,1'b0,1'b1,64'h1,8'h00,32'h0,32'h1,32'h0000_003F,8'd9}                           // R9 size zero
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_mode = 1'b0, in_round = 1'b0, in_sat = 1'b0, in_dec = 1'b0;
  logic [63:0] in_acc = '0;
  logic [7:0]  in_amt = '0;
  logic [31:0] in_ctl = '0;
  logic        out_valid;
  logic [31:0] out_result, out_ctl;
  int          errors = 0;
  int          checks = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  afx_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_round(in_round), .in_sat(in_sat), .in_dec(in_dec),
    .in_acc(in_acc), .in_amt(in_amt), .in_ctl(in_ctl),
    .out_valid(out_valid), .out_result(out_result), .out_ctl(out_ctl)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    in_valid = 1'b1; in_mode = v.mode; in_round = v.rnd; in_sat = v.sat; in_dec = v.dec;
    in_acc = v.acc; in_amt = v.amt; in_ctl = v.ctl;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset valid", {31'b0, out_valid}, 32'h0);
    check("R11 reset result", out_result, 32'h0);
    check("R11 reset ctl", out_ctl, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      check($sformatf("R%0d vec%0d valid", TBL[i].req, i), {31'b0, out_valid}, 32'h1);
      check($sformatf("R%0d vec%0d result", TBL[i].req, i), out_result, TBL[i].er);
      check($sformatf("R%0d vec%0d ctl", TBL[i].req, i), out_ctl, TBL[i].ec);
    end

    // R11 hold while idle: last vector left result 1, ctl 0x3F
    in_acc = 64'hFFFF_FFFF_FFFF_FFFF; in_ctl = 32'h1234_5678;
    @(negedge clk);
    check("R11 idle valid", {31'b0, out_valid}, 32'h0);
    check("R11 idle result hold", out_result, 32'h1);
    check("R11 idle ctl hold", out_ctl, 32'h0000_003F);

    // R11 reset during a request
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_mode = 1'b0; in_acc = 64'h55; in_amt = 8'h0;
    @(negedge clk);
    check("R11 reset wins valid", {31'b0, out_valid}, 32'h0);
    check("R11 reset wins result", out_result, 32'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule